// File: doc/BRIEF.md
# Configurable Wait-State Bus Cycle Controller

This block runs the external bus cycles of an 8051-style core. It handles three kinds of transfer: instruction fetch, data read and data write. Each kind has its own length, counted in core clocks and taken from a run-time writable control register. The core hands the block a request, and the block answers with the matching strobe, an address-valid flag and a held write byte. When the cycle ends, the block raises a one-clock completion pulse, which carries the byte captured from the bus for fetches and reads.

Two inputs from the prefetch logic act only on instruction fetches. A stall input holds a fetch in its current clock. An abort input throws away a fetch that is no longer wanted. Data reads and writes ignore both inputs. The same control register also carries two enable bits, one for the prefetch queue and one for the branch cache. The block only drives these bits out to that logic.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold its request steady. The completion side is a plain pulse with no back-pressure, so the consumer must take `done` and `rdata` in the clock they appear.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset the control register reads all ones. `pf_en` and `bc_en` are high, every strobe and `addr_valid` are low, and `req_ready` is high, so an untouched fetch lasts 4 clocks.
- R2: A fetch (`req_kind` 2'b00) drives `fetch_stb` for exactly F+1 clocks, where F is control bits [1:0]. Strobe clock 1 is the clock after acceptance. `done` pulses in the clock after the last strobe clock, and `rdata` then holds the `bus_rdata` value present during that last strobe clock.
- R3: A data read (`req_kind` 2'b01, and also the encoding 2'b11) drives `rd_stb` for R+1 clocks, where R is control bits [3:2]. It has the same `done`/`rdata` timing as a fetch.
- R4: A write (`req_kind` 2'b10) drives `wr_stb` for W+1 clocks, where W is control bits [5:4], for any address. `bus_wdata` equals the accepted `req_wdata` through every strobe clock, and `done` pulses in the clock after.
- R5: When F equals R, a fetch and a read show identical strobe length and `done` timing.
- R6: Each clock of a fetch in which `pf_stall` is high (and `fetch_abort` is low) adds one clock to `fetch_stb`.
- R7: `pf_stall` has no effect on the length of reads or writes.
- R8: When `fetch_abort` is high during a fetch strobe clock, `fetch_stb` is low in the next clock, `done` stays low for that fetch, and `req_ready` is high. `fetch_abort` has no effect on reads or writes.
- R9: Only one cycle runs at a time. `req_ready` is low in every strobe clock, exactly one strobe is high in a strobe clock, and a request is accepted again from the clock of `done` onwards.
- R10: A control-register write (`cfg_we`) changes only cycles accepted afterwards. A cycle already running keeps the length it was accepted with.
- R11: `pf_en` follows control bit 6 and `bc_en` follows control bit 7, from the clock after the register write.
- R12: `addr_valid` is high and `bus_addr` equals the accepted `req_addr` in every strobe clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control-register write enable |
| cfg_wdata | input | 3*CW+2 | Control-register write value |
| pf_en | output | 1 | Prefetch queue enable (control bit 6) |
| bc_en | output | 1 | Branch cache enable (control bit 7) |
| req_valid | input | 1 | Cycle request valid |
| req_ready | output | 1 | Ready to accept a request |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write byte |
| pf_stall | input | 1 | Prefetch reload stall, fetch only |
| fetch_abort | input | 1 | Discard the running fetch |
| fetch_stb | output | 1 | Instruction-fetch strobe |
| rd_stb | output | 1 | Data-read strobe |
| wr_stb | output | 1 | Data-write strobe |
| addr_valid | output | 1 | Address valid on the bus |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured fetch/read byte |

## Verification
The assertions assume the requester follows the handshake: it never changes `req_kind`, `req_addr` or `req_wdata` in the clock a request is taken. They also assume `fetch_abort` and `pf_stall` arrive only as described, with stall meaningful only while a fetch runs. The stimulus raises `req_valid` only when `req_ready` is high and drops it right after acceptance. It holds the abort and stall lines low outside the strobe clocks it targets, and it changes `bus_rdata` every strobe clock so that a capture in the wrong clock shows up as a wrong byte.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'b00,
    K_READ  = 2'b01,
    K_WRITE = 2'b10,
    K_ALTRD = 2'b11
  } kind_e;

  function automatic logic is_fetch(input kind_e k);
    return k == K_FETCH;
  endfunction
endpackage

// File: rtl/bcc_cfg_reg.sv
module bcc_cfg_reg #(
  parameter int CW = 2,
  localparam int RW = 3 * CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] wdata,
  output logic [CW-1:0] fetch_len_m1,
  output logic [CW-1:0] read_len_m1,
  output logic [CW-1:0] write_len_m1,
  output logic          pf_en,
  output logic          bc_en
);
  logic [RW-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else if (we) q <= wdata;
  end

  assign fetch_len_m1 = q[CW-1:0];
  assign read_len_m1  = q[2*CW-1:CW];
  assign write_len_m1 = q[3*CW-1:2*CW];
  assign pf_en        = q[3*CW];
  assign bc_en        = q[3*CW+1];

  // R11
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (pf_en == $past(wdata[3*CW])) && (bc_en == $past(wdata[3*CW+1])));
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  kind_e         start_kind,
  input  logic [CW-1:0] start_len_m1,
  input  logic          stall,
  input  logic          abort,
  output logic          busy,
  output kind_e         kind,
  output logic          last,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic          fetch_hold, fetch_kill;

  assign fetch_kill = busy && is_fetch(kind) && abort;
  assign fetch_hold = busy && is_fetch(kind) && stall && !abort;
  assign last       = busy && (cnt_q == '0) && !fetch_kill && !fetch_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      kind  <= K_FETCH;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        kind  <= start_kind;
        cnt_q <= start_len_m1;
      end else if (fetch_kill) begin
        busy <= 1'b0;
      end else if (fetch_hold) begin
        cnt_q <= cnt_q;
      end else if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R8
  abort_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == K_FETCH && abort) |=> (!busy && !done));
  // R6
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == K_FETCH && stall && !abort) |=> (busy && $stable(cnt_q)));
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 2,
  localparam int RW = 3 * CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_wdata,
  output logic          pf_en,
  output logic          bc_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          pf_stall,
  input  logic          fetch_abort,
  output logic          fetch_stb,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          addr_valid,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic [DW-1:0] rdata
);
  logic [CW-1:0] f_len, r_len, w_len, sel_len;
  logic          busy, last, start;
  kind_e         kind, in_kind;

  bcc_cfg_reg #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .fetch_len_m1(f_len), .read_len_m1(r_len), .write_len_m1(w_len),
    .pf_en(pf_en), .bc_en(bc_en)
  );

  assign in_kind   = kind_e'(req_kind);
  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  always_comb begin
    unique case (in_kind)
      K_FETCH: sel_len = f_len;
      K_WRITE: sel_len = w_len;
      default: sel_len = r_len;
    endcase
  end

  bcc_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_kind(in_kind),
    .start_len_m1(sel_len), .stall(pf_stall), .abort(fetch_abort),
    .busy(busy), .kind(kind), .last(last), .done(done)
  );

  assign fetch_stb  = busy && kind == K_FETCH;
  assign wr_stb     = busy && kind == K_WRITE;
  assign rd_stb     = busy && (kind == K_READ || kind == K_ALTRD);
  assign addr_valid = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      rdata     <= '0;
    end else begin
      if (start) begin
        bus_addr  <= req_addr;
        bus_wdata <= req_wdata;
      end
      if (last && kind != K_WRITE) rdata <= bus_rdata;
    end
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_stb, rd_stb, wr_stb}));
  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb || rd_stb || wr_stb) |-> !req_ready);
  // R4
  wdata_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !start) |=> (!wr_stb || $stable(bus_wdata)));
  // R12
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !start) |=> (!addr_valid || start || $stable(bus_addr)));
endmodule

// File: tb/test_bus_cycle_ctrl.sv
module test_bus_cycle_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        pf_en, bc_en, req_ready;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        pf_stall = 1'b0, fetch_abort = 1'b0;
  logic        fetch_stb, rd_stb, wr_stb, addr_valid, done;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, rdata;
  logic [7:0]  bus_rdata = '0;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_ctrl i_bus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pf_en(pf_en), .bc_en(bc_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .pf_stall(pf_stall), .fetch_abort(fetch_abort), .fetch_stb(fetch_stb),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .addr_valid(addr_valid),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .rdata(rdata)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic stb_of(input logic [1:0] k);
    case (k)
      2'b00:   return fetch_stb;
      2'b10:   return wr_stb;
      default: return rd_stb;
    endcase
  endfunction

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // Runs one cycle; expected strobe length derives from the requirements.
  task automatic do_cycle(input logic [1:0] k, input int nlen, input int s_from,
                          input int s_len, input int ab_at, input int cfg_at,
                          input logic [7:0] cfg_v, input string tag);
    int exp_len, cnt;
    logic aborted;
    logic [15:0] ad;
    logic [7:0]  wd;
    aborted = (k == 2'b00) && (ab_at > 0);
    exp_len = aborted ? ab_at : nlen + ((k == 2'b00) ? s_len : 0);
    ad = 16'h1200 + 16'(nlen * 17 + k);
    wd = 8'h5A ^ 8'(nlen + k);
    @(negedge clk);
    chk(req_ready, {tag, " R9 ready before request"}, req_ready, 1);
    req_valid = 1'b1; req_kind = k; req_addr = ad; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_addr = '0; req_wdata = '0;
    cnt = 0;
    while (stb_of(k) && cnt < 20) begin
      cnt++;
      chk(!req_ready && !done, {tag, " R9 busy during strobe"}, req_ready, 0);
      chk($countones({fetch_stb, rd_stb, wr_stb}) == 1, {tag, " R9 single strobe"},
          $countones({fetch_stb, rd_stb, wr_stb}), 1);
      chk(addr_valid && bus_addr == ad, {tag, " R12 address"}, int'(bus_addr), int'(ad));
      if (k == 2'b10) chk(bus_wdata == wd, {tag, " R4 write data"}, bus_wdata, wd);
      bus_rdata   = 8'h40 + 8'(cnt);
      pf_stall    = (cnt >= s_from) && (cnt < s_from + s_len);
      fetch_abort = (cnt == ab_at);
      cfg_we      = (cnt == cfg_at);
      cfg_wdata   = cfg_v;
      @(negedge clk);
    end
    pf_stall = 1'b0; fetch_abort = 1'b0; cfg_we = 1'b0;
    chk(cnt == exp_len, {tag, " strobe length"}, cnt, exp_len);
    if (aborted) begin
      chk(!done, {tag, " R8 no done after abort"}, done, 0);
      chk(req_ready, {tag, " R8 ready after abort"}, req_ready, 1);
    end else begin
      chk(done, {tag, " done pulse"}, done, 1);
      chk(req_ready, {tag, " R9 ready at done"}, req_ready, 1);
      if (k != 2'b10)
        chk(rdata == 8'h40 + 8'(exp_len), {tag, " captured byte"}, rdata, 8'h40 + exp_len);
    end
  endtask

  task automatic t_reset;
    chk(pf_en && bc_en, "R1 enables set", {pf_en, bc_en}, 3);
    chk(!fetch_stb && !rd_stb && !wr_stb && !addr_valid, "R1 strobes low",
        {fetch_stb, rd_stb, wr_stb, addr_valid}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
    do_cycle(2'b00, 4, 99, 0, 0, 0, 8'h00, "R1 default fetch");
  endtask

  task automatic t_lengths;
    for (int f = 0; f < 4; f++) begin
      set_cfg(8'hC0 | 8'(f) | 8'((3 - f) << 2) | 8'(((f + 1) % 4) << 4));
      do_cycle(2'b00, f + 1, 99, 0, 0, 0, 8'h00, "R2 fetch");
      do_cycle(2'b01, 4 - f, 99, 0, 0, 0, 8'h00, "R3 read");
      do_cycle(2'b11, 4 - f, 99, 0, 0, 0, 8'h00, "R3 read alt code");
      do_cycle(2'b10, ((f + 1) % 4) + 1, 99, 0, 0, 0, 8'h00, "R4 write");
    end
  endtask

  task automatic t_equal;
    set_cfg(8'hC0 | 8'h01 | 8'h04);
    do_cycle(2'b00, 2, 99, 0, 0, 0, 8'h00, "R5 equal fetch");
    do_cycle(2'b01, 2, 99, 0, 0, 0, 8'h00, "R5 equal read");
  endtask

  task automatic t_stall;
    set_cfg(8'hC0 | 8'h02 | 8'h08 | 8'h10);
    do_cycle(2'b00, 3, 2, 3, 0, 0, 8'h00, "R6 fetch stall mid");
    do_cycle(2'b00, 3, 3, 1, 0, 0, 8'h00, "R6 fetch stall last");
    do_cycle(2'b01, 3, 1, 4, 0, 0, 8'h00, "R7 read stall ignored");
    do_cycle(2'b10, 2, 1, 4, 0, 0, 8'h00, "R7 write stall ignored");
  endtask

  task automatic t_abort;
    set_cfg(8'hFF);
    do_cycle(2'b00, 4, 99, 0, 2, 0, 8'h00, "R8 fetch abort");
    do_cycle(2'b00, 4, 1, 2, 1, 0, 8'h00, "R8 abort over stall");
    do_cycle(2'b01, 4, 99, 0, 2, 0, 8'h00, "R8 read abort ignored");
    do_cycle(2'b10, 4, 99, 0, 1, 0, 8'h00, "R8 write abort ignored");
  endtask

  task automatic t_cfg_midcycle;
    set_cfg(8'hFF);
    do_cycle(2'b01, 4, 99, 0, 0, 1, 8'hC0, "R10 read keeps length");
    do_cycle(2'b01, 1, 99, 0, 0, 0, 8'h00, "R10 next read new length");
    do_cycle(2'b10, 1, 99, 0, 0, 1, 8'hF0, "R10 write keeps length");
    do_cycle(2'b10, 4, 99, 0, 0, 0, 8'h00, "R10 next write new length");
  endtask

  task automatic t_enables;
    set_cfg(8'h40);
    chk(pf_en && !bc_en, "R11 pf only", {bc_en, pf_en}, 1);
    set_cfg(8'h80);
    chk(!pf_en && bc_en, "R11 bc only", {bc_en, pf_en}, 2);
    set_cfg(8'h00);
    chk(!pf_en && !bc_en, "R11 both off", {bc_en, pf_en}, 0);
    do_cycle(2'b00, 1, 99, 0, 0, 0, 8'h00, "R2 fetch with enables off");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_equal();
    t_stall();
    t_abort();
    t_cfg_midcycle();
    t_enables();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule